// File: doc/BRIEF.md
# Byte-Wide Configuration Stream Loader

This block takes in a configuration stream one byte at a time. It samples one byte on each rising edge of its clock. Before any data is taken it checks a fixed seven-byte header. After the header it accepts a parameterised number of fixed-length frames. Each frame opens with a start marker and closes with a check byte. Every payload byte leaves through a write port, with a one-cycle strobe and a sequential address, into an external configuration memory. The stream has no length field and no CRC. Loading is complete when the last frame the memory holds has been stored.

Several loaders can share one data bus and one clock. Each loader's `cascade_o` drives the `sel_i` of the next loader. `cascade_o` is high while the header is loaded, so every device on the bus takes the header at the same time. It drops once the header is accepted, and rises again when the device's memory is full, which hands the bus to the next device. A malformed marker or check byte freezes the loader and pulls `fault_n_o` low. That state holds until `prog_n` is pulsed low or reset is applied. `done_o` rises after a fixed number of start-up clocks that follow the last frame.

Top module: `cfg_stream_loader`

## Requirements
- R1: While `rst_n` is low, `cascade_o`=1, `fault_n_o`=1, `done_o`=0 and `mem_we_o`=0.
- R2: The loader ignores the byte present at the first rising edge after `rst_n` or `prog_n` returns high. The first byte is taken at the second edge.
- R3: Bit 0 of `data_i` is the first-listed bit of each pattern. The header is 0xFF, 0xFF, 0x4F (preamble), 0xFF, 0xFF, 0xFF, 0x4B (end-of-header check). When the seventh byte is accepted, `cascade_o` falls at that edge.
- R4: A frame is 0x7F (start marker), then FRAME_BYTES payload bytes, then 0x4B (end check). Each payload byte sampled at edge N gives `mem_we_o`=1 after edge N, with that byte on `mem_data_o`. The address on `mem_addr_o` starts at 0 and counts up by one per payload byte.
- R5: A wrong header byte, start marker or end check byte drives `fault_n_o` low after that edge and drives `cascade_o` low. Both stay low, with no further writes, whatever bytes follow, until `prog_n` or `rst_n` goes low.
- R6: A byte sampled while `sel_i` is low is ignored. It causes no write, no fault and no advance of the parser.
- R7: When the end check of frame FRAME_COUNT is accepted, `cascade_o` rises after that edge. Later bytes cause no write and no fault.
- R8: `done_o` rises exactly STARTUP_CYC edges after the edge that accepted the last end check byte. These start-up edges are counted whatever `data_i` and `sel_i` carry.
- R9: A low level on `prog_n` at a rising edge restarts the loader. After that edge `fault_n_o`=1, `done_o`=0 and `cascade_o`=1, and the next payload is written from address 0.
- R10: When two loaders are chained, the second writes nothing until the first has raised `cascade_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, one byte per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_n | input | 1 | Synchronous active-low restart of configuration |
| sel_i | input | 1 | Chip select; bytes count only while high |
| data_i | input | 8 | Stream byte, bit 0 is the first-listed bit |
| cascade_o | output | 1 | Chain status toward the next loader's select |
| fault_n_o | output | 1 | Low once a framing error is latched |
| done_o | output | 1 | High after the start-up clocks that follow the last frame |
| mem_we_o | output | 1 | One-cycle write strobe per payload byte |
| mem_addr_o | output | ADDR_W | Sequential payload address from 0 |
| mem_data_o | output | 8 | Payload byte being written |

## Verification
The bench drives two chained loaders with the following streams:
- A well-formed stream. This shows that the header is taken in parallel and that the frames are handed from the first loader to the second.
- A stream with a select gap in the middle of a frame. This shows that a deselected byte is skipped rather than stored or flagged.
- A stream whose only error is a corrupted end check byte. This shows that the latched fault stops writing even when valid frames follow.
- A header whose preamble has its bits reversed. This shows whether the loader reads bit 0 as the first-listed bit.

The start-up clocks after the first loader fills overlap the second loader's first frame. This pins the rise of `done_o` to an exact edge.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

   typedef enum logic [2:0] {
      ST_ARM,
      ST_HDR,
      ST_FSTART,
      ST_FDATA,
      ST_FEND,
      ST_BOOT,
      ST_DONE,
      ST_FAULT
   } cfgl_state_e;

   // Patterns are listed first bit first; the bus carries that bit on bit 0.
   function automatic logic [7:0] d0_first(input logic [7:0] pat);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = pat[7-i];
      return r;
   endfunction

   localparam logic [7:0] FILL_B  = 8'hFF;
   localparam logic [7:0] PRE_B   = d0_first(8'b11110010);
   localparam logic [7:0] CHK_B   = d0_first(8'b11010010);
   localparam logic [7:0] START_B = d0_first(8'b11111110);

   localparam int HDR_LEN = 7;
   localparam int PRE_IDX = 2;
   localparam int EOH_IDX = HDR_LEN - 1;

endpackage

// File: rtl/cfgl_hdr_match.sv
module cfgl_hdr_match
   import cfgl_pkg::*;
#(
   parameter bit CHECK_FILL = 1'b1
) (
   input  logic [2:0] idx_i,
   input  logic [7:0] byte_i,
   output logic       ok_o
);

   logic is_pre;
   logic is_eoh;

   assign is_pre = (idx_i == 3'(PRE_IDX));
   assign is_eoh = (idx_i == 3'(EOH_IDX));

   generate
      if (CHECK_FILL) begin : g_strict
         always_comb begin
            if (is_pre)      ok_o = (byte_i == PRE_B);
            else if (is_eoh) ok_o = (byte_i == CHK_B);
            else             ok_o = (byte_i == FILL_B);
         end
      end else begin : g_loose
         always_comb begin
            if (is_pre)      ok_o = (byte_i == PRE_B);
            else if (is_eoh) ok_o = (byte_i == CHK_B);
            else             ok_o = 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/cfgl_frame_track.sv
module cfgl_frame_track #(
   parameter int FRAME_BYTES = 4,
   parameter int FRAME_COUNT = 3,
   parameter int ADDR_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              byte_i,
   input  logic              frame_i,
   output logic              last_byte_o,
   output logic              last_frame_o,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int BW = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1;
   localparam int FW = (FRAME_COUNT > 1) ? $clog2(FRAME_COUNT) : 1;

   logic [BW-1:0]     byte_cnt_q;
   logic [FW-1:0]     frame_cnt_q;
   logic [ADDR_W-1:0] addr_q;

   assign last_byte_o  = (byte_cnt_q  == BW'(FRAME_BYTES - 1));
   assign last_frame_o = (frame_cnt_q == FW'(FRAME_COUNT - 1));
   assign addr_o       = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_cnt_q  <= '0;
         frame_cnt_q <= '0;
         addr_q      <= '0;
      end else if (clr_i) begin
         byte_cnt_q  <= '0;
         frame_cnt_q <= '0;
         addr_q      <= '0;
      end else begin
         if (byte_i) begin
            addr_q     <= addr_q + 1'b1;
            byte_cnt_q <= last_byte_o ? '0 : byte_cnt_q + 1'b1;
         end
         if (frame_i && !last_frame_o)
            frame_cnt_q <= frame_cnt_q + 1'b1;
      end
   end

   // R4
   payload_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_i && !clr_i) |=> (addr_o == $past(addr_o) + 1'b1));

endmodule

// File: rtl/cfgl_wr_port.sv
module cfgl_wr_port #(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        data_i,
   output logic              we_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [7:0]        data_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_o   <= 1'b0;
         addr_o <= '0;
         data_o <= '0;
      end else begin
         we_o <= en_i;
         if (en_i) begin
            addr_o <= addr_i;
            data_o <= data_i;
         end
      end
   end

   // R4
   wr_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_o && $past(we_o) && $past(en_i, 2)) |-> (addr_o == $past(addr_o) + 1'b1));

endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
   import cfgl_pkg::*;
#(
   parameter int  FRAME_BYTES = 4,
   parameter int  FRAME_COUNT = 3,
   parameter int  STARTUP_CYC = 6,
   parameter bit  CHECK_FILL  = 1'b1,
   localparam int DEPTH       = FRAME_BYTES * FRAME_COUNT,
   localparam int ADDR_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_n,
   input  logic              sel_i,
   input  logic [7:0]        data_i,
   output logic              cascade_o,
   output logic              fault_n_o,
   output logic              done_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [7:0]        mem_data_o
);

   localparam int CW = $clog2(STARTUP_CYC + 1);

   generate
      if (FRAME_BYTES < 1) begin : g_bad_bytes
         $error("FRAME_BYTES must be at least 1");
      end
      if (FRAME_COUNT < 1) begin : g_bad_frames
         $error("FRAME_COUNT must be at least 1");
      end
      if (STARTUP_CYC < 1) begin : g_bad_boot
         $error("STARTUP_CYC must be at least 1");
      end
   endgenerate

   cfgl_state_e       st_q, st_d;
   logic [2:0]        hdr_idx_q;
   logic [CW-1:0]     boot_cnt_q;
   logic              hdr_ok;
   logic              last_byte, last_frame;
   logic              step_byte, step_frame, trk_clr;
   logic [ADDR_W-1:0] wr_addr;

   cfgl_hdr_match #(.CHECK_FILL(CHECK_FILL)) u_hdr (
      .idx_i  (hdr_idx_q),
      .byte_i (data_i),
      .ok_o   (hdr_ok)
   );

   assign step_byte  = (st_q == ST_FDATA) && sel_i && prog_n;
   assign step_frame = (st_q == ST_FEND) && sel_i && (data_i == CHK_B);
   assign trk_clr    = !prog_n || (st_q == ST_ARM);

   cfgl_frame_track #(
      .FRAME_BYTES (FRAME_BYTES),
      .FRAME_COUNT (FRAME_COUNT),
      .ADDR_W      (ADDR_W)
   ) u_trk (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr_i        (trk_clr),
      .byte_i       (step_byte),
      .frame_i      (step_frame),
      .last_byte_o  (last_byte),
      .last_frame_o (last_frame),
      .addr_o       (wr_addr)
   );

   cfgl_wr_port #(.ADDR_W(ADDR_W)) u_wr (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (step_byte),
      .addr_i (wr_addr),
      .data_i (data_i),
      .we_o   (mem_we_o),
      .addr_o (mem_addr_o),
      .data_o (mem_data_o)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_ARM:    st_d = ST_HDR;
         ST_HDR:    if (sel_i) begin
                       if (!hdr_ok)                       st_d = ST_FAULT;
                       else if (hdr_idx_q == 3'(EOH_IDX)) st_d = ST_FSTART;
                    end
         ST_FSTART: if (sel_i) st_d = (data_i == START_B) ? ST_FDATA : ST_FAULT;
         ST_FDATA:  if (sel_i && last_byte) st_d = ST_FEND;
         ST_FEND:   if (sel_i) begin
                       if (data_i != CHK_B) st_d = ST_FAULT;
                       else                 st_d = last_frame ? ST_BOOT : ST_FSTART;
                    end
         ST_BOOT:   if (boot_cnt_q == CW'(STARTUP_CYC - 1)) st_d = ST_DONE;
         ST_DONE:   st_d = ST_DONE;
         ST_FAULT:  st_d = ST_FAULT;
         default:   st_d = ST_FAULT;
      endcase
      if (!prog_n) st_d = ST_ARM;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_ARM;
         hdr_idx_q  <= '0;
         boot_cnt_q <= '0;
      end else begin
         st_q <= st_d;
         if (!prog_n || st_q == ST_ARM)
            hdr_idx_q <= '0;
         else if (st_q == ST_HDR && sel_i && hdr_ok)
            hdr_idx_q <= hdr_idx_q + 1'b1;
         if (st_q == ST_BOOT)
            boot_cnt_q <= boot_cnt_q + 1'b1;
         else
            boot_cnt_q <= '0;
      end
   end

   assign cascade_o = (st_q == ST_ARM) || (st_q == ST_HDR) ||
                      (st_q == ST_BOOT) || (st_q == ST_DONE);
   assign fault_n_o = (st_q != ST_FAULT);
   assign done_o    = (st_q == ST_DONE);

   // R5
   fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault_n_o && prog_n) |=> (!fault_n_o && !mem_we_o));

   // R6
   desel_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FDATA && !sel_i) |=> !mem_we_o);

   // R3
   hdr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cascade_o) && fault_n_o) |-> $past(sel_i));

   // R8
   done_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> (cascade_o && $past(cascade_o) && !mem_we_o));

endmodule

// File: tb/test_cfg_stream_loader.sv
module test_cfg_stream_loader;

   localparam int FB = 4;
   localparam int FC = 3;
   localparam int AW = 4;
   localparam logic [7:0] K_PRE = 8'h4F, K_CHK = 8'h4B, K_START = 8'h7F;

   typedef struct packed {
      logic [AW-1:0] addr;
      logic [7:0]    data;
   } wr_item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0, prog_n = 1'b1, sel0 = 1'b1;
   logic [7:0] bus = 8'hFF;
   logic casc0, flt0, done0, we0, casc1, flt1, done1, we1;
   logic [AW-1:0] ad0, ad1;
   logic [7:0] dt0, dt1;

   int n_chk = 0, n_err = 0;
   bit finished = 1'b0;
   wr_item_t q0[$];
   wr_item_t q1[$];
   int exp_addr[2];

   always #2 clk = ~clk;

   cfg_stream_loader #(.FRAME_BYTES(FB), .FRAME_COUNT(FC), .STARTUP_CYC(6)) i_cfg_stream_loader (
      .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .sel_i(sel0), .data_i(bus),
      .cascade_o(casc0), .fault_n_o(flt0), .done_o(done0),
      .mem_we_o(we0), .mem_addr_o(ad0), .mem_data_o(dt0));

   cfg_stream_loader #(.FRAME_BYTES(FB), .FRAME_COUNT(FC), .STARTUP_CYC(6)) i_cfg_stream_loader_nxt (
      .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .sel_i(casc0), .data_i(bus),
      .cascade_o(casc1), .fault_n_o(flt1), .done_o(done1),
      .mem_we_o(we1), .mem_addr_o(ad1), .mem_data_o(dt1));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   // Drive at a negedge; return at the next negedge, after the sampling edge.
   task automatic send(input logic [7:0] b);
      bus = b;
      @(negedge clk);
   endtask

   task automatic push(input int dev, input logic [7:0] b);
      wr_item_t it;
      it.addr = AW'(exp_addr[dev]);
      it.data = b;
      if (dev == 0) q0.push_back(it); else q1.push_back(it);
      exp_addr[dev]++;
   endtask

   task automatic send_header(input logic [7:0] pre);
      send(8'hFF); send(8'hFF); send(pre);
      send(8'hFF); send(8'hFF); send(8'hFF); send(K_CHK);
   endtask

   // gap=1 drops sel0 for two junk bytes after the first payload byte.
   task automatic send_frame(input int dev, input logic [7:0] seed,
                             input logic [7:0] endb, input bit expect_wr, input bit gap);
      send(K_START);
      for (int i = 0; i < FB; i++) begin
         if (expect_wr) push(dev, seed + 8'(i));
         send(seed + 8'(i));
         if (gap && i == 0) begin
            sel0 = 1'b0;
            send(8'h00);
            send(8'h13);
            sel0 = 1'b1;
         end
      end
      send(endb);
   endtask

   task automatic restart();
      prog_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      prog_n = 1'b1;
      exp_addr[0] = 0;
      exp_addr[1] = 0;
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (we0) begin
         if (q0.size() == 0) check("R7 unexpected write dev0", {24'h0, dt0}, 32'hFFFF);
         else begin
            wr_item_t e;
            e = q0.pop_front();
            check("R4 dev0 address", 32'(ad0), 32'(e.addr));
            check("R4 dev0 data", 32'(dt0), 32'(e.data));
         end
      end
      if (we1) begin
         check("R10 dev1 write while dev0 not full", 32'(casc0), 32'd1);
         if (q1.size() == 0) check("R7 unexpected write dev1", {24'h0, dt1}, 32'hFFFF);
         else begin
            wr_item_t e;
            e = q1.pop_front();
            check("R4 dev1 address", 32'(ad1), 32'(e.addr));
            check("R4 dev1 data", 32'(dt1), 32'(e.data));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      exp_addr[0] = 0;
      exp_addr[1] = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 cascade0", 32'(casc0), 1); check("R1 fault0", 32'(flt0), 1);
      check("R1 done0", 32'(done0), 0);    check("R1 we0", 32'(we0), 0);
      check("R1 cascade1", 32'(casc1), 1); check("R1 done1", 32'(done1), 0);
      rst_n = 1'b1;
      send(8'h00);                       // R2: ignored, would fault if taken
      send_header(K_PRE);
      check("R3 cascade0 after header", 32'(casc0), 0);
      check("R3 cascade1 after header", 32'(casc1), 0);
      check("R2 fault0 after header", 32'(flt0), 1);
      check("R2 fault1 after header", 32'(flt1), 1);
      send_frame(0, 8'h10, K_CHK, 1'b1, 1'b0);
      send_frame(0, 8'h20, K_CHK, 1'b1, 1'b1);
      check("R6 fault0 after deselected bytes", 32'(flt0), 1);
      send_frame(0, 8'h30, K_CHK, 1'b1, 1'b0);
      check("R7 cascade0 after last frame", 32'(casc0), 1);
      check("R7 done0 not yet", 32'(done0), 0);
      // dev1's first frame overlaps dev0's start-up clocks
      send(K_START);
      for (int i = 0; i < FB; i++) begin push(1, 8'h40 + 8'(i)); send(8'h40 + 8'(i)); end
      check("R8 done0 after five start-up edges", 32'(done0), 0);
      send(K_CHK);
      check("R8 done0 after six start-up edges", 32'(done0), 1);
      check("R7 fault0 after ignored bytes", 32'(flt0), 1);
      send_frame(1, 8'h50, K_CHK, 1'b1, 1'b0);
      send_frame(1, 8'h60, K_CHK, 1'b1, 1'b0);
      check("R10 cascade1 after filling", 32'(casc1), 1);
      repeat (5) send(8'hFF);
      check("R8 done1 early", 32'(done1), 0);
      send(8'hFF);
      check("R8 done1", 32'(done1), 1);
      check("R10 dev1 writes all seen", 32'(q1.size()), 0);
      check("R4 dev0 writes all seen", 32'(q0.size()), 0);

      // Corrupted end check byte
      restart();
      check("R9 cascade0 after restart", 32'(casc0), 1);
      check("R9 done0 after restart", 32'(done0), 0);
      check("R9 done1 after restart", 32'(done1), 0);
      send(8'h00);
      send_header(K_PRE);
      send_frame(0, 8'h70, 8'h4A, 1'b1, 1'b0);
      check("R5 fault0 after bad end check", 32'(flt0), 0);
      check("R5 cascade0 after bad end check", 32'(casc0), 0);
      send_frame(0, 8'h80, K_CHK, 1'b0, 1'b0);
      check("R5 fault0 still latched", 32'(flt0), 0);
      check("R5 no writes after fault", 32'(q0.size()), 0);

      // Bit-reversed preamble
      restart();
      check("R9 fault0 cleared", 32'(flt0), 1);
      send(8'h00);
      send(8'hFF); send(8'hFF); send(8'hF2);
      check("R3 fault0 on reversed preamble", 32'(flt0), 0);

      // Clean restart writes from address 0
      restart();
      send(8'h00);
      send_header(K_PRE);
      send_frame(0, 8'hA0, K_CHK, 1'b1, 1'b0);
      check("R9 fault0 after clean reload", 32'(flt0), 1);
      check("R9 writes from zero seen", 32'(q0.size()), 0);
      @(negedge clk);
      finish_run();
   end

endmodule